// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a one-byte mailbox in each direction between a host bus and an embedded controller. The host sees a two-location window selected by a one-bit offset. A host write at either offset loads the inbound byte. A status bit records whether the write used the data offset (0) or the command offset (1), so the controller can tell command bytes from parameter bytes.

Host reads at offset 0 return the outbound reply byte. Host reads at offset 1 return a status byte. Reading the reply byte is also the acknowledge: it drops the outbound-full flag and the host interrupt. For this reason host software reads the status before the reply byte.

The controller has two interfaces. It pops inbound bytes through a pop strobe, and each byte comes with its command/data marker. It pushes reply bytes through a push strobe. Two controller input pins feed the busy and protocol-mode status bits straight through to the host. The host interrupt is a level that stays high while a reply byte is waiting.

Top module: `host_mailbox`

## Requirements
- R1: After reset the inbound-full, outbound-full and overrun flags are 0, the interrupt is low, and the command marker is 0.
- R2: `hostRdata` is combinational. With `hostSel`=0 it returns the outbound byte. With `hostSel`=1 it returns the status byte: bit 0 outbound-full, bit 1 inbound-full, bit 2 busy, bit 3 command marker, bit 7 protocol mode, and bits 6..4 (and any bits above 7) zero.
- R3: A host write stores `hostWdata` as the inbound byte, sets inbound-full and sets the command marker to `hostSel`. The new values are visible from the next cycle.
- R4: `ctlPopData`/`ctlPopCmd` always present the inbound byte and its marker. A pop clears inbound-full on the next cycle, unless a host write occurs in the same cycle, in which case the write wins.
- R5: A host read with `hostSel`=0 clears outbound-full on the next cycle. A host read with `hostSel`=1 has no side effect.
- R6: A controller push loads the outbound byte and sets outbound-full. It wins over a clearing host read in the same cycle.
- R7: A push while outbound-full is set, with no clearing read in that cycle, overwrites the byte and sets a sticky overrun flag. Only reset clears the overrun flag.
- R8: `hostIrq` equals the outbound-full flag on every cycle.
- R9: Status bits 2 and 7 follow `ctlBusy` and `ctlTokenMode` in the same cycle, with no register.
- R10: Host writes never change the outbound byte or outbound-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host offset: 0 data, 1 command/status |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data |
| hostIrq | output | 1 | Host interrupt level |
| ctlPop | input | 1 | Controller pop strobe |
| ctlPopData | output | DATA_W | Inbound byte |
| ctlPopCmd | output | 1 | Inbound byte came through the command offset |
| ctlInFull | output | 1 | Inbound byte not yet popped |
| ctlPush | input | 1 | Controller push strobe |
| ctlPushData | input | DATA_W | Reply byte |
| ctlOutFull | output | 1 | Reply byte not yet read by host |
| ctlOverrun | output | 1 | Sticky: reply byte was overwritten |
| ctlBusy | input | 1 | Busy status pin |
| ctlTokenMode | input | 1 | Protocol-mode status pin |

## Verification
A behavioural model in the bench is compared on every clock against all outputs and against the read data at both offsets.

Directed sequences first exercise writes at each offset, which separates the command marker's two values. They then compare status reads against data reads, which tells the side-effect-free read from the acknowledging one. Same-cycle collisions (write against pop, push against clearing read) expose the priority choices. Back-to-back pushes expose overrun stickiness.

A long pseudo-random stretch then toggles every strobe and pin at once to catch interactions the directed cases miss.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadIn;    // capture host byte into inbound register
    logic inSelCmd;  // marker value for that byte
    logic loadOut;   // capture controller byte into outbound register
  } mbox_strobe_t;

  localparam int STAT_OUT_FULL = 0;
  localparam int STAT_IN_FULL  = 1;
  localparam int STAT_BUSY     = 2;
  localparam int STAT_CMD      = 3;
  localparam int STAT_TOKEN    = 7;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         ctlPop,
  input  logic         ctlPush,
  output mbox_strobe_t strb,
  output logic         inFull,
  output logic         outFull,
  output logic         overrun
);
  logic clrRead;

  assign clrRead = hostRd && !hostSel;

  always_comb begin
    strb.loadIn   = hostWr;
    strb.inSelCmd = hostSel;
    strb.loadOut  = ctlPush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (hostWr)      inFull <= 1'b1;
      else if (ctlPop) inFull <= 1'b0;

      if (ctlPush) begin
        outFull <= 1'b1;
        if (outFull && !clrRead) overrun <= 1'b1;
      end else if (clrRead) begin
        outFull <= 1'b0;
      end
    end
  end

  AST_WRITE_SETS_IN: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> inFull); // R3
  AST_POP_CLEARS_IN: assert property (@(posedge clk) disable iff (!rstN)
    (ctlPop && !hostWr) |=> !inFull); // R4
  AST_READ_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostSel && !ctlPush) |=> !outFull); // R5
  AST_PUSH_SETS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ctlPush |=> outFull); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R7
  AST_NO_SILENT_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctlPush && outFull && !clrRead) |=> overrun); // R7
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ctlPushData,
  input  logic              hostSel,
  input  logic              inFull,
  input  logic              outFull,
  input  logic              ctlBusy,
  input  logic              ctlTokenMode,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] ctlPopData,
  output logic              ctlPopCmd
);
  localparam int STAT_W = 8;
  localparam int PAD_W  = DATA_W - STAT_W;

  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;
  logic              cmdMark;
  logic [STAT_W-1:0] statByte;
  logic [DATA_W-1:0] statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg   <= '0;
      outReg  <= '0;
      cmdMark <= 1'b0;
    end else begin
      if (strb.loadIn) begin
        inReg   <= hostWdata;
        cmdMark <= strb.inSelCmd;
      end
      if (strb.loadOut) outReg <= ctlPushData;
    end
  end

  always_comb begin
    statByte                = '0;
    statByte[STAT_OUT_FULL] = outFull;
    statByte[STAT_IN_FULL]  = inFull;
    statByte[STAT_BUSY]     = ctlBusy;
    statByte[STAT_CMD]      = cmdMark;
    statByte[STAT_TOKEN]    = ctlTokenMode;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign statWord = {{PAD_W{1'b0}}, statByte};
    end else begin : g_nopad
      assign statWord = statByte[DATA_W-1:0];
    end
  endgenerate

  assign hostRdata  = hostSel ? statWord : outReg;
  assign ctlPopData = inReg;
  assign ctlPopCmd  = cmdMark;

  AST_MARKER_TRACKS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIn |=> (cmdMark == $past(hostSel))); // R3
  AST_IN_BYTE_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIn |=> (ctlPopData == $past(hostWdata))); // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOut |=> $stable(outReg)); // R10
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  input  logic              ctlPop,
  output logic [DATA_W-1:0] ctlPopData,
  output logic              ctlPopCmd,
  output logic              ctlInFull,
  input  logic              ctlPush,
  input  logic [DATA_W-1:0] ctlPushData,
  output logic              ctlOutFull,
  output logic              ctlOverrun,
  input  logic              ctlBusy,
  input  logic              ctlTokenMode
);
  mbox_strobe_t strb;
  logic inFull, outFull, overrun;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .ctlPop(ctlPop), .ctlPush(ctlPush), .strb(strb),
    .inFull(inFull), .outFull(outFull), .overrun(overrun)
  );

  mbox_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .ctlPushData(ctlPushData), .hostSel(hostSel), .inFull(inFull),
    .outFull(outFull), .ctlBusy(ctlBusy), .ctlTokenMode(ctlTokenMode),
    .hostRdata(hostRdata), .ctlPopData(ctlPopData), .ctlPopCmd(ctlPopCmd)
  );

  assign hostIrq    = outFull;
  assign ctlInFull  = inFull;
  assign ctlOutFull = outFull;
  assign ctlOverrun = overrun;

  AST_IRQ_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostSel && !ctlPush) |=> !hostIrq); // R8
endmodule

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [W-1:0] hostWdata = '0;
  logic [W-1:0] hostRdata;
  logic hostIrq;
  logic ctlPop = 1'b0;
  logic [W-1:0] ctlPopData;
  logic ctlPopCmd, ctlInFull;
  logic ctlPush = 1'b0;
  logic [W-1:0] ctlPushData = '0;
  logic ctlOutFull, ctlOverrun;
  logic ctlBusy = 1'b0, ctlTokenMode = 1'b0;

  always #10 clk = ~clk;

  host_mailbox #(.DATA_W(W)) u_host_mailbox (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .ctlPop(ctlPop), .ctlPopData(ctlPopData), .ctlPopCmd(ctlPopCmd),
    .ctlInFull(ctlInFull), .ctlPush(ctlPush), .ctlPushData(ctlPushData),
    .ctlOutFull(ctlOutFull), .ctlOverrun(ctlOverrun), .ctlBusy(ctlBusy),
    .ctlTokenMode(ctlTokenMode)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [W-1:0] mIn = '0, mOut = '0;
  bit mCmd = 0, mInFull = 0, mOutFull = 0, mOvr = 0;

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expRead(input bit sel);
    logic [W-1:0] s;
    s = '0;
    s[0] = mOutFull; s[1] = mInFull; s[2] = ctlBusy; s[3] = mCmd; s[7] = ctlTokenMode;
    return sel ? s : mOut;
  endfunction

  task automatic compareAll();
    check(W'(hostIrq), W'(mOutFull), "R8 irq");
    check(W'(ctlInFull), W'(mInFull), "R3 R4 inFull");
    check(W'(ctlOutFull), W'(mOutFull), "R5 R6 outFull");
    check(W'(ctlOverrun), W'(mOvr), "R7 overrun");
    check(ctlPopData, mIn, "R4 popData");
    check(W'(ctlPopCmd), W'(mCmd), "R4 popCmd");
    check(hostRdata, expRead(hostSel), "R2 R9 hostRdata");
  endtask

  // apply inputs at negedge, compare combinational read, clock, update model, compare
  task automatic step(input bit sel, input bit wr, input bit rd, input logic [W-1:0] wd,
                      input bit pop, input bit push, input logic [W-1:0] pd,
                      input bit busy, input bit tok);
    bit clrRd;
    hostSel = sel; hostWr = wr; hostRd = rd; hostWdata = wd;
    ctlPop = pop; ctlPush = push; ctlPushData = pd; ctlBusy = busy; ctlTokenMode = tok;
    #1;
    check(hostRdata, expRead(sel), "R2 R9 read before edge");
    @(posedge clk);
    cycles++;
    clrRd = rd && !sel;
    if (wr) begin mIn = wd; mCmd = sel; mInFull = 1; end
    else if (pop) mInFull = 0;
    if (push) begin
      if (mOutFull && !clrRd) mOvr = 1;
      mOut = pd; mOutFull = 1;
    end else if (clrRd) mOutFull = 0;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, '0, ctlBusy, ctlTokenMode);
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(W'(hostIrq), '0, "R1 irq after reset");
    check(W'({ctlInFull, ctlOutFull, ctlOverrun, ctlPopCmd}), '0, "R1 flags after reset");
    hostSel = 1'b1; #1;
    check(hostRdata, '0, "R1 status after reset");
    hostSel = 1'b0;
    idle();
    // R3: write at data offset, then at command offset
    step(0, 1, 0, 8'h5A, 0, 0, '0, 0, 0);
    step(1, 0, 1, '0, 0, 0, '0, 0, 0);            // status read, R5 no side effect
    step(1, 1, 0, 8'hC3, 0, 0, '0, 0, 0);         // command write
    check(W'(ctlPopCmd), W'(1), "R3 command marker");
    // R4: pop, then pop colliding with write
    step(0, 0, 0, '0, 1, 0, '0, 0, 0);
    check(W'(ctlInFull), '0, "R4 pop clears inFull");
    step(0, 1, 0, 8'h11, 1, 0, '0, 0, 0);
    check(W'(ctlInFull), W'(1), "R4 write wins over pop");
    // R10: writes do not touch outbound side
    step(0, 1, 0, 8'h77, 0, 0, '0, 0, 0);
    check(W'(ctlOutFull), '0, "R10 write leaves outFull");
    // R6 push, R5 status read keeps, data read clears
    step(0, 0, 0, '0, 0, 1, 8'hA5, 0, 0);
    check(W'(hostIrq), W'(1), "R6 R8 push raises irq");
    step(1, 0, 1, '0, 0, 0, '0, 0, 0);
    check(W'(hostIrq), W'(1), "R5 status read keeps irq");
    step(0, 0, 1, '0, 0, 0, '0, 0, 0);
    check(W'(hostIrq), '0, "R5 data read drops irq");
    // R6: push and clearing read in same cycle
    step(0, 0, 0, '0, 0, 1, 8'h01, 0, 0);
    step(0, 0, 1, '0, 0, 1, 8'h02, 0, 0);
    check(W'(ctlOutFull), W'(1), "R6 push wins over read");
    check(W'(ctlOverrun), '0, "R7 no overrun when read clears");
    // R7: push onto full
    step(0, 0, 0, '0, 0, 1, 8'h03, 0, 0);
    check(W'(ctlOverrun), W'(1), "R7 overrun set");
    step(0, 0, 1, '0, 0, 0, '0, 0, 0);
    idle();
    check(W'(ctlOverrun), W'(1), "R7 overrun sticky");
    // R9: pins straight through
    step(1, 0, 0, '0, 0, 0, '0, 1, 0);
    step(1, 0, 0, '0, 0, 0, '0, 0, 1);
    step(1, 0, 0, '0, 0, 0, '0, 1, 1);
    // R1: reset clears overrun
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    mIn = '0; mOut = '0; mCmd = 0; mInFull = 0; mOutFull = 0; mOvr = 0;
    compareAll();
    // random stretch
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1] & lfsr[9], lfsr[2], lfsr[15:8], lfsr[3],
           lfsr[4] & lfsr[10], lfsr[23:16], lfsr[5], lfsr[6]);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule